// File: doc/BRIEF.md
# Multipurpose Pin Port for a Serial Channel

This block owns the four general-purpose pins attached to one serial channel. Each pin gets its own 2-bit configuration field. That field picks whether the pin is an input, a register-driven output, or an output that carries one of the channel's internal clocks. One pin also carries the channel's request-to-send line, or an end-of-transmission marker. That pin is either pin 2 or pin 1, chosen by pin 2's configuration.

A host reaches three byte-wide registers over a simple synchronous bus:

- **Pin setup register** (address 0): holds the four configuration fields.
- **Drive and watch register** (address 1): the upper nibble arms change detection per pin, and the lower nibble holds the inverted output levels.
- **Pin status register** (address 2, read only): the upper nibble shows latched change flags, and the lower nibble shows the synchronized pin levels.

Reading the status register acknowledges the change flags. Their OR forms the interrupt. Pins used as clock or flow-control inputs by other logic remain readable in the status register at the same time.

Top module: `uart_pin_port`

## Requirements
- R1: After reset the setup and drive/watch registers read 0x00, every pin output enable is 0 and the interrupt is low.
- R2: A pin whose field is 00 is an input: its output enable is 0.
- R3: A pin whose field is 01, and which is not carrying request-to-send, is enabled and driven with the inverse of its bit in the drive/watch register's low nibble (bit n for pin n).
- R4: Clock codes: pin 3 gives the 16x transmit clock on 10 and the 1x transmit clock on 11. Pin 2 gives the 1x receive clock on 10 and the 16x receive clock on 11. Pin 1 gives the 1x receive clock on 11. Pin 0 gives the 1x transmit clock on 10 and the 16x transmit clock on 11.
- R5: Pin 1 with field 10 is enabled and driven low.
- R6: Request-to-send is placed on pin 2 when pin 2's field (setup bits 5:4) is 01. Otherwise it is placed on pin 1 when pin 1's field (bits 3:2) is 01.
- R7: On the request-to-send pin the drive is selected in this order:
  - `rts_level` when `rts_mode` is 1;
  - otherwise `eot_level` when `eot_mode` is 1;
  - otherwise the inverse of that pin's register bit.
- R8: Status bits 3:0 report the pin input levels (1 = high), two clock cycles after a change at the pin.
- R9: A change flag (status bit 4+n for pin n) sets on either edge of the synchronized level only while drive/watch bit 4+n is 1 and the pin's field is 00. Otherwise it reads 0.
- R10: A read of the status register clears the flags, except that an edge detected in the same cycle as the read leaves its flag set.
- R11: The interrupt is high exactly when any change flag is set.
- R12: The setup and drive/watch registers read back what was written. Writes to address 2 change nothing, and address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (status read acknowledges flags) |
| reg_addr | input | 2 | Register address: 0 setup, 1 drive/watch, 2 status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| pin_in | input | 4 | Levels seen at the four pins |
| tx_clk_1x | input | 1 | Transmit bit clock |
| tx_clk_16x | input | 1 | Transmit oversampling clock |
| rx_clk_1x | input | 1 | Receive bit clock |
| rx_clk_16x | input | 1 | Receive oversampling clock |
| rts_mode | input | 1 | Route request-to-send to its pin |
| eot_mode | input | 1 | Route end-of-transmission to the request-to-send pin |
| rts_level | input | 1 | Request-to-send level from the channel |
| eot_level | input | 1 | End-of-transmission level from the channel |
| pin_out | output | 4 | Drive value for each pin |
| pin_oe | output | 4 | Output enable for each pin |
| chg_irq | output | 1 | Change-of-state interrupt |

## Verification
The hardest case to reach is a status read in the very cycle a new edge is detected. There, the clear and the set meet at one register.

The bench counts the synchronizer and the edge register itself. It changes a pin level on a falling clock edge and waits through two rising edges. It then starts the status read so that the read and the detected edge share the third rising edge. It then checks that the interrupt stays high, and that a second read clears it.

// File: rtl/uart_pin_pkg.sv
// Package: shared constants for the multipurpose pin port.
// Assumes byte-wide registers and a 2-bit configuration field per pin.
package uart_pin_pkg;
    localparam int NUM_PINS   = 4;
    localparam int FIELD_W    = 2;
    localparam int REG_W      = NUM_PINS * FIELD_W;
    localparam int ADDR_W     = 2;

    localparam logic [ADDR_W-1:0] ADDR_SETUP  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_DRIVE  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd2;

    typedef enum logic [FIELD_W-1:0] {
        SRC_INPUT = 2'b00,
        SRC_REG   = 2'b01,
        SRC_ALT_A = 2'b10,
        SRC_ALT_B = 2'b11
    } pin_src_e;
endpackage

// File: rtl/upp_regs.sv
// Module: register file of the pin port.
// Holds the setup and drive/watch registers, returns read data combinationally,
// and emits a one-cycle pulse when the status register is read.
// Assumes at most one access per cycle; a write to the status address is dropped.
module upp_regs
    import uart_pin_pkg::*;
#(
    parameter int DW = REG_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    input  logic [DW-1:0] status_val,
    output logic [DW-1:0] setup_q,
    output logic [DW-1:0] drive_q,
    output logic [DW-1:0] reg_rdata,
    output logic          status_rd
);
    // Store host writes to the two writable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            setup_q <= '0;
            drive_q <= '0;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_SETUP) setup_q <= reg_wdata;
            if (reg_addr == ADDR_DRIVE) drive_q <= reg_wdata;
        end
    end

    // Select read data by address; unused addresses return zero.
    always_comb begin
        case (reg_addr)
            ADDR_SETUP:  reg_rdata = setup_q;
            ADDR_DRIVE:  reg_rdata = drive_q;
            ADDR_STATUS: reg_rdata = status_val;
            default:     reg_rdata = '0;
        endcase
    end

    // Flag acknowledge pulse for the change detectors.
    assign status_rd = reg_rd && (reg_addr == ADDR_STATUS);
endmodule

// File: rtl/upp_chg_det.sv
// Module: per-pin input synchronizer and latched change-of-state flag.
// Assumes SYNC_STAGES >= 2. The flag is held at 0 while not armed.
// A set in the same cycle as an acknowledge wins.
module upp_chg_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    input  logic arm,
    input  logic ack,
    output logic level,
    output logic edge_seen,
    output logic flag
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Bring the asynchronous pin level into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_raw};
    end

    assign level = sync_q[SYNC_STAGES-1];

    // Remember the last synchronized level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    assign edge_seen = level ^ prev_q;

    // Latch edges while armed; acknowledge clears unless an edge arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)         flag <= 1'b0;
        else if (!arm)      flag <= 1'b0;
        else if (edge_seen) flag <= 1'b1;
        else if (ack)       flag <= 1'b0;
    end
endmodule

// File: rtl/upp_pin_mux.sv
// Module: output source selector of one pin.
// Code 00 releases the pin; 01 drives the inverted register bit or the
// request-to-send source; 10 and 11 pick alternate signals given by the parent.
// ALT_A_LOW replaces alternate A with a constant low drive.
module upp_pin_mux
    import uart_pin_pkg::*;
#(
    parameter bit ALT_A_LOW = 1'b0
) (
    input  logic [FIELD_W-1:0] code,
    input  logic               reg_bit,
    input  logic               rts_here,
    input  logic               rts_drive,
    input  logic               alt_a,
    input  logic               alt_b,
    output logic               drive,
    output logic               oe
);
    // Decode the pin's field into a drive value and an enable.
    always_comb begin
        case (pin_src_e'(code))
            SRC_INPUT: begin drive = 1'b0; oe = 1'b0; end
            SRC_REG:   begin drive = rts_here ? rts_drive : ~reg_bit; oe = 1'b1; end
            SRC_ALT_A: begin drive = ALT_A_LOW ? 1'b0 : alt_a; oe = 1'b1; end
            default:   begin drive = alt_b; oe = 1'b1; end
        endcase
    end
endmodule

// File: rtl/uart_pin_port.sv
// Module: four-pin multipurpose port of one serial channel (top).
// Wires the register file, per-pin change detectors and per-pin source muxes.
// Places request-to-send on pin 2 or pin 1, and forms the change interrupt.
// Assumes clock inputs are already in, or safe to pass from, their own domain.
module uart_pin_port
    import uart_pin_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                tx_clk_1x,
    input  logic                tx_clk_16x,
    input  logic                rx_clk_1x,
    input  logic                rx_clk_16x,
    input  logic                rts_mode,
    input  logic                eot_mode,
    input  logic                rts_level,
    input  logic                eot_level,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                chg_irq
);
    localparam int RTS_PRIMARY  = 2;
    localparam int RTS_FALLBACK = 1;

    logic [REG_W-1:0]    setup_q;
    logic [REG_W-1:0]    drive_q;
    logic [REG_W-1:0]    status_val;
    logic                status_rd;
    logic [NUM_PINS-1:0] levels;
    logic [NUM_PINS-1:0] edge_pulse;
    logic [NUM_PINS-1:0] chg_flags;
    logic [NUM_PINS-1:0] arm;
    logic [NUM_PINS-1:0] rts_here;
    logic [NUM_PINS-1:0] alt_a;
    logic [NUM_PINS-1:0] alt_b;
    logic                rts_on_primary;
    logic                rts_reg_bit;
    logic                rts_drive;

    upp_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .status_val (status_val),
        .setup_q    (setup_q),
        .drive_q    (drive_q),
        .reg_rdata  (reg_rdata),
        .status_rd  (status_rd)
    );

    // Status register layout: flags on top, live levels below.
    assign status_val = {chg_flags, levels};

    // Request-to-send placement: primary pin when it selects 01, else fallback.
    assign rts_on_primary = (setup_q[RTS_PRIMARY*FIELD_W +: FIELD_W] == SRC_REG);
    assign rts_reg_bit    = rts_on_primary ? drive_q[RTS_PRIMARY] : drive_q[RTS_FALLBACK];

    // Request-to-send pin source with flow control taking priority.
    always_comb begin
        if (rts_mode)      rts_drive = rts_level;
        else if (eot_mode) rts_drive = eot_level;
        else               rts_drive = ~rts_reg_bit;
    end

    // Per-pin alternate clock sources.
    always_comb begin
        alt_a = {tx_clk_16x, rx_clk_1x, 1'b0,      tx_clk_1x};
        alt_b = {tx_clk_1x,  rx_clk_16x, rx_clk_1x, tx_clk_16x};
    end

    // Which pin carries request-to-send.
    always_comb begin
        rts_here               = '0;
        rts_here[RTS_PRIMARY]  = rts_on_primary;
        rts_here[RTS_FALLBACK] = !rts_on_primary;
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        // Detection runs only for armed input pins.
        assign arm[i] = drive_q[NUM_PINS + i] &&
                        (setup_q[i*FIELD_W +: FIELD_W] == SRC_INPUT);

        upp_chg_det #(
            .SYNC_STAGES (SYNC_STAGES)
        ) u_det (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_raw   (pin_in[i]),
            .arm       (arm[i]),
            .ack       (status_rd),
            .level     (levels[i]),
            .edge_seen (edge_pulse[i]),
            .flag      (chg_flags[i])
        );

        upp_pin_mux #(
            .ALT_A_LOW (i == RTS_FALLBACK)
        ) u_mux (
            .code      (setup_q[i*FIELD_W +: FIELD_W]),
            .reg_bit   (drive_q[i]),
            .rts_here  (rts_here[i]),
            .rts_drive (rts_drive),
            .alt_a     (alt_a[i]),
            .alt_b     (alt_b[i]),
            .drive     (pin_out[i]),
            .oe        (pin_oe[i])
        );
    end

    // Interrupt request from any pending change.
    assign chg_irq = |chg_flags;
endmodule

// File: rtl/uart_pin_port_chk.sv
// Module: property checker for the pin port, bound to the top module.
// Assumes visibility of the top's register and detector signals.
module uart_pin_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [1:0] reg_addr,
    input logic [7:0] setup_q,
    input logic [7:0] drive_q,
    input logic [3:0] pin_out,
    input logic [3:0] pin_oe,
    input logic [3:0] chg_flags,
    input logic [3:0] edge_pulse,
    input logic       status_rd,
    input logic       chg_irq
);
    // R2
    pin0_input_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_q[1:0] == 2'b00) |-> !pin_oe[0]);

    // R5
    pin1_reserved_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_q[3:2] == 2'b10) |-> (pin_oe[1] && !pin_out[1]));

    // R9
    disarmed_flag_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!drive_q[4]) |=> !chg_flags[0]);

    // R10
    read_clears_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && (edge_pulse == 4'b0000)) |=> !chg_irq);

    // R12
    status_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == 2'd2)) |=> ($stable(setup_q) && $stable(drive_q)));
endmodule

bind uart_pin_port uart_pin_port_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .setup_q    (setup_q),
    .drive_q    (drive_q),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .chg_flags  (chg_flags),
    .edge_pulse (edge_pulse),
    .status_rd  (status_rd),
    .chg_irq    (chg_irq)
);

// File: tb/uart_pin_port_tb.sv
// Directed bench for the pin port: one task per scenario, each self-checking.
// Inputs change and outputs are sampled on falling edges.
module uart_pin_port_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       reg_wr, reg_rd;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic [3:0] pin_in;
    logic       tx_clk_1x, tx_clk_16x, rx_clk_1x, rx_clk_16x;
    logic       rts_mode, eot_mode, rts_level, eot_level;
    logic [3:0] pin_out, pin_oe;
    logic       chg_irq;
    int         total = 0;
    int         bad   = 0;
    logic [7:0] rv;

    always #2.5 clk = ~clk;

    uart_pin_port u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pin_in(pin_in), .tx_clk_1x(tx_clk_1x), .tx_clk_16x(tx_clk_16x),
        .rx_clk_1x(rx_clk_1x), .rx_clk_16x(rx_clk_16x), .rts_mode(rts_mode),
        .eot_mode(eot_mode), .rts_level(rts_level), .eot_level(eot_level),
        .pin_out(pin_out), .pin_oe(pin_oe), .chg_irq(chg_irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // All bus tasks start and end on a falling edge.
    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(posedge clk); @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        rd_reg(2'd0, rv); check("R1 setup", rv, 8'h00);
        rd_reg(2'd1, rv); check("R1 drive", rv, 8'h00);
        check("R1 oe", {4'h0, pin_oe}, 8'h00);
        check("R1 irq", {7'h0, chg_irq}, 8'h00);
        check("R2 inputs released", {4'h0, pin_oe}, 8'h00);
    endtask

    task automatic t_reg_out;
        wr_reg(2'd0, 8'h55);
        wr_reg(2'd1, 8'h05);
        check("R3 drive", {4'h0, pin_out}, 8'h0A);
        check("R3 oe", {4'h0, pin_oe}, 8'h0F);
        wr_reg(2'd1, 8'h00);
        rts_mode = 1'b1; rts_level = 1'b0; #1;
        check("R6 rts on pin2", {4'h0, pin_out}, 8'h0B);
        wr_reg(2'd0, 8'h45);
        check("R6 rts on pin1", {4'h0, pin_out[1], pin_oe[2]}, 8'h00);
        rts_mode = 1'b0; eot_mode = 1'b1; eot_level = 1'b0; #1;
        check("R7 eot source", {7'h0, pin_out[1]}, 8'h00);
        rts_mode = 1'b1; rts_level = 1'b1; #1;
        check("R7 rts priority", {7'h0, pin_out[1]}, 8'h01);
        rts_mode = 1'b0; eot_mode = 1'b0; #1;
        check("R7 register fallback", {7'h0, pin_out[1]}, 8'h01);
        wr_reg(2'd1, 8'h02);
        check("R7 register inverse", {7'h0, pin_out[1]}, 8'h00);
    endtask

    task automatic t_clocks;
        wr_reg(2'd0, 8'hAA);
        tx_clk_16x = 1'b1; tx_clk_1x = 1'b0; rx_clk_1x = 1'b1; rx_clk_16x = 1'b0; #1;
        check("R4 codes 10 a", {4'h0, pin_out}, 8'h0C);
        check("R5 pin1 reserved", {6'h0, pin_oe[1], pin_out[1]}, 8'h02);
        tx_clk_16x = 1'b0; tx_clk_1x = 1'b1; rx_clk_1x = 1'b0; rx_clk_16x = 1'b1; #1;
        check("R4 codes 10 b", {4'h0, pin_out}, 8'h01);
        wr_reg(2'd0, 8'hFF);
        check("R4 codes 11", {4'h0, pin_out}, 8'h0C);
        check("R4 oe", {4'h0, pin_oe}, 8'h0F);
    endtask

    task automatic t_levels;
        wr_reg(2'd0, 8'h00);
        wr_reg(2'd1, 8'h00);
        pin_in = 4'b1010;
        idle(1);
        rd_reg(2'd2, rv); check("R8 level latency", rv, 8'h00);
        idle(2);
        rd_reg(2'd2, rv); check("R8 levels R9 disarmed", rv, 8'h0A);
    endtask

    task automatic t_change;
        wr_reg(2'd1, 8'hF0);
        idle(3);
        rd_reg(2'd2, rv);
        check("R11 idle irq", {7'h0, chg_irq}, 8'h00);
        pin_in = 4'b0011;
        idle(4);
        check("R11 irq set", {7'h0, chg_irq}, 8'h01);
        rd_reg(2'd2, rv); check("R9 flags both edges", rv, 8'h93);
        check("R10 cleared", {7'h0, chg_irq}, 8'h00);
        rd_reg(2'd2, rv); check("R10 flags zero", rv, 8'h03);
        wr_reg(2'd0, 8'h04);
        pin_in = 4'b0001;
        idle(4);
        rd_reg(2'd2, rv); check("R9 output pin no flag", rv, 8'h01);
        wr_reg(2'd0, 8'h00);
    endtask

    task automatic t_collide;
        idle(3);
        rd_reg(2'd2, rv);
        pin_in = 4'b0000;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        rd_reg(2'd2, rv);
        check("R10 set wins over clear", {7'h0, chg_irq}, 8'h01);
        rd_reg(2'd2, rv);
        check("R10 second read clears", {7'h0, chg_irq}, 8'h00);
    endtask

    task automatic t_bus;
        wr_reg(2'd0, 8'h9C);
        wr_reg(2'd1, 8'h3A);
        wr_reg(2'd2, 8'hFF);
        rd_reg(2'd0, rv); check("R12 setup readback", rv, 8'h9C);
        rd_reg(2'd1, rv); check("R12 drive readback", rv, 8'h3A);
        rd_reg(2'd3, rv); check("R12 unused address", rv, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
        pin_in = '0; tx_clk_1x = 0; tx_clk_16x = 0; rx_clk_1x = 0; rx_clk_16x = 0;
        rts_mode = 0; eot_mode = 0; rts_level = 0; eot_level = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_reg_out;
        t_clocks;
        t_levels;
        t_change;
        t_collide;
        t_bus;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule